// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one configurable logic cell of the kind that sits behind a product-term array in a programmable logic device. It receives a sum-of-products term, a second product term for the polarity/combine gate, a direct pad input, a bank of global clock, clock-enable and set/reset lines, and dedicated product-term clock, enable, set and reset signals. Static configuration inputs choose how these are used.

The cell has one storage element. It can run as an edge-triggered D register, a level-sensitive D latch or a toggle flip-flop. The element can take its data from the gated logic path or straight from the pad, which gives a fast input register. Beside the stored output, the cell drives a combinatorial output at the same time, so two unrelated functions leave one cell.

All logic runs on one system clock `clk`. The selected macrocell clock, enable, set and reset are sampled as ordinary level signals on that clock. An "active edge" is a sample of the selected clock, after optional inversion, that is 1 where the previous sample was 0. The stored output is a register, so every change of it appears one system-clock cycle after the sample that caused it.

Top module: `pld_macrocell`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, `reg_out` becomes 0, and the clock-history sample is taken as 1, so a selected clock that is already high when reset ends does not count as an edge.
- R2: `comb_out` is `sum_pt` XOR a second operand chosen by `cfg_xor_sel`: 0 gives constant 0, 1 gives constant 1 (inversion), 2 gives `xor_pt`, 3 gives constant 0. It follows its inputs within the same cycle.
- R3: The data stored is `pad_in` when `cfg_pad_in` is 1, otherwise the value on `comb_out`.
- R4: With `cfg_mode` 0 or 3 (D register), on an active edge with enable high and no set or reset, `reg_out` takes the data one cycle later.
- R5: With `cfg_mode` 1 (latch), in every cycle where the selected clock level is 1 and enable is high, `reg_out` takes the data one cycle later; otherwise it holds.
- R6: With `cfg_mode` 2 (toggle), on an active edge with enable high, `reg_out` inverts when the data is 1 and holds when it is 0.
- R7: `cfg_clk_sel` below NUM_GCLK picks `gclk[cfg_clk_sel]`; any larger value picks `pt_clk`. `cfg_clk_inv` = 1 inverts the selected clock before use.
- R8: `cfg_ce_src` 0 or 3 means always enabled, 1 picks `gce[cfg_ce_idx]`, 2 picks `pt_ce`. A global index out of range reads 0.
- R9: `cfg_set_src` and `cfg_rst_src` each use 0 or 3 for none, 1 for `gsr[index]`, 2 for `pt_set` / `pt_rst`. Both are active high. An active set makes `reg_out` 1 in the next cycle, whatever the mode, clock or enable.
- R10: When the selected set and reset are both active, `reg_out` becomes 0 in the next cycle, whatever the clock or enable.
- R11: With no set or reset, `reg_out` holds when enable is low, or, in register and toggle modes, when there is no active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sum_pt | input | 1 | Sum-of-products data term |
| xor_pt | input | 1 | Product term for the XOR gate |
| pad_in | input | 1 | Direct pad input |
| gclk | input | NUM_GCLK | Global clock lines |
| pt_clk | input | 1 | Product-term clock |
| gce | input | NUM_GCE | Global clock-enable lines |
| pt_ce | input | 1 | Product-term clock enable |
| gsr | input | NUM_GSR | Global set/reset lines |
| pt_set | input | 1 | Product-term set |
| pt_rst | input | 1 | Product-term reset |
| cfg_mode | input | 2 | Storage mode |
| cfg_xor_sel | input | 2 | XOR second-operand select |
| cfg_pad_in | input | 1 | Store from pad instead of logic path |
| cfg_clk_sel | input | CLK_SEL_W | Clock source select |
| cfg_clk_inv | input | 1 | Clock polarity invert |
| cfg_ce_src | input | 2 | Enable source |
| cfg_ce_idx | input | CE_IDX_W | Global enable index |
| cfg_set_src | input | 2 | Set source |
| cfg_set_idx | input | SR_IDX_W | Global set index |
| cfg_rst_src | input | 2 | Reset source |
| cfg_rst_idx | input | SR_IDX_W | Global reset index |
| reg_out | output | 1 | Stored output |
| comb_out | output | 1 | Combinatorial output |

## Verification
The bench goes after a set and reset that arrive together. A design that let set win would drive `reg_out` to 1 instead of 0. It also checks that the latch goes back to holding as soon as the clock level drops. A design that treated latch mode as edge-triggered would miss updates while the level stays high. Toggle mode is run with data 0 on active edges, which shows whether the cell wrongly loads or inverts. A selected clock that is high when reset ends must not count as an edge, and the cell must ignore edges while enable is low. Random sweeps over every mode, source, polarity and index combination catch a wrong index mapping, because a wrong mapping makes the cell react to a line it should ignore.

// File: rtl/pld_mc_pkg.sv
// Package: shared encodings for the configurable macrocell.
// Assumes configuration fields are two bits wide where they carry these enums.
package pld_mc_pkg;

    typedef enum logic [1:0] {
        MC_DREG     = 2'd0,
        MC_DLATCH   = 2'd1,
        MC_TFF      = 2'd2,
        MC_DREG_ALT = 2'd3
    } mc_mode_e;

    typedef enum logic [1:0] {
        SRC_OFF     = 2'd0,
        SRC_GLOBAL  = 2'd1,
        SRC_PTERM   = 2'd2,
        SRC_OFF_ALT = 2'd3
    } mc_src_e;

    typedef enum logic [1:0] {
        XOR_ZERO     = 2'd0,
        XOR_ONE      = 2'd1,
        XOR_PTERM    = 2'd2,
        XOR_ZERO_ALT = 2'd3
    } mc_xor_e;

endpackage

// File: rtl/mc_logic_path.sv
// Module: combinational data path of the macrocell.
// Forms the XOR of the sum term with a selected operand, drives the
// combinatorial output, and chooses the storage data (logic path or pad).
// Assumes all inputs are stable levels within a system-clock cycle.
module mc_logic_path
    import pld_mc_pkg::*;
(
    input  logic       sum_pt,
    input  logic       xor_pt,
    input  logic       pad_in,
    input  logic [1:0] cfg_xor_sel,
    input  logic       cfg_pad_in,
    output logic       comb_val,
    output logic       store_d
);

    logic xor_operand;

    // Choose the second XOR operand from the configuration.
    always_comb begin
        unique case (mc_xor_e'(cfg_xor_sel))
            XOR_ONE:   xor_operand = 1'b1;
            XOR_PTERM: xor_operand = xor_pt;
            default:   xor_operand = 1'b0;
        endcase
    end

    // Form the combinatorial result and the storage data source.
    always_comb begin
        comb_val = sum_pt ^ xor_operand;
        store_d  = cfg_pad_in ? pad_in : comb_val;
    end

endmodule

// File: rtl/mc_line_pick.sv
// Module: picks one control line from a global bank or a product term.
// A source code of "off" returns OFF_VAL. An out-of-range global index
// returns 0. Used for clock enable, set and reset.
module mc_line_pick
    import pld_mc_pkg::*;
#(
    parameter int   NUM     = 2,
    parameter int   IDX_W   = 1,
    parameter logic OFF_VAL = 1'b0
) (
    input  logic [1:0]     src,
    input  logic [IDX_W-1:0] idx,
    input  logic [NUM-1:0] glob,
    input  logic           pt,
    output logic           line
);

    logic glob_hit;

    // Index the global bank; out-of-range indices read as 0.
    always_comb begin
        glob_hit = 1'b0;
        for (int i = 0; i < NUM; i++) begin
            if (int'(idx) == i) glob_hit = glob[i];
        end
    end

    // Apply the source selection.
    always_comb begin
        unique case (mc_src_e'(src))
            SRC_GLOBAL: line = glob_hit;
            SRC_PTERM:  line = pt;
            default:    line = OFF_VAL;
        endcase
    end

endmodule

// File: rtl/mc_clk_pick.sv
// Module: selects the macrocell clock level and applies polarity.
// Select values below NUM_GCLK pick a global clock; larger values pick
// the product-term clock. Assumes clocks are sampled levels.
module mc_clk_pick #(
    parameter int NUM_GCLK = 4,
    parameter int SEL_W    = 3
) (
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                pt_clk,
    input  logic [SEL_W-1:0]    sel,
    input  logic                inv,
    output logic                lvl
);

    logic raw;

    // Pick the raw clock source from the select value.
    always_comb begin
        raw = pt_clk;
        for (int i = 0; i < NUM_GCLK; i++) begin
            if (int'(sel) == i) raw = gclk[i];
        end
    end

    // Apply the configured polarity.
    always_comb lvl = raw ^ inv;

endmodule

// File: rtl/mc_storage.sv
// Module: the single storage element in D-register, D-latch or T mode.
// Works on samples taken at the system clock: an active edge is a 0 then 1
// sequence of the selected level. Reset beats set; both ignore clock and
// enable. Assumes synchronous active-low system reset.
module mc_storage
    import pld_mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       lvl,
    input  logic       ce,
    input  logic       set_l,
    input  logic       rst_l,
    input  logic       d,
    output logic       q
);

    logic prev_lvl;
    logic act_edge;
    logic q_nxt;

    // Detect an active edge from the previous and current level samples.
    always_comb act_edge = lvl & ~prev_lvl;

    // Compute the next stored value with reset/set priority over the mode.
    always_comb begin
        q_nxt = q;
        if (rst_l) begin
            q_nxt = 1'b0;
        end else if (set_l) begin
            q_nxt = 1'b1;
        end else if (ce) begin
            unique case (mc_mode_e'(mode))
                MC_DLATCH: if (lvl) q_nxt = d;
                MC_TFF:    if (act_edge && d) q_nxt = ~q;
                default:   if (act_edge) q_nxt = d;
            endcase
        end
    end

    // Hold the stored value and the clock history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= 1'b0;
            prev_lvl <= 1'b1;
        end else begin
            q        <= q_nxt;
            prev_lvl <= lvl;
        end
    end

endmodule

// File: rtl/pld_macrocell.sv
// Module: configurable output macrocell (top).
// Combines the logic path, clock selection, control-line selection and the
// storage element. Drives a stored and a combinatorial output together.
// Assumes static configuration and a single system clock.
module pld_macrocell #(
    parameter  int NUM_GCLK  = 4,
    parameter  int NUM_GCE   = 2,
    parameter  int NUM_GSR   = 2,
    localparam int CLK_SEL_W = $clog2(NUM_GCLK + 1),
    localparam int CE_IDX_W  = (NUM_GCE > 1) ? $clog2(NUM_GCE) : 1,
    localparam int SR_IDX_W  = (NUM_GSR > 1) ? $clog2(NUM_GSR) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sum_pt,
    input  logic                 xor_pt,
    input  logic                 pad_in,
    input  logic [NUM_GCLK-1:0]  gclk,
    input  logic                 pt_clk,
    input  logic [NUM_GCE-1:0]   gce,
    input  logic                 pt_ce,
    input  logic [NUM_GSR-1:0]   gsr,
    input  logic                 pt_set,
    input  logic                 pt_rst,
    input  logic [1:0]           cfg_mode,
    input  logic [1:0]           cfg_xor_sel,
    input  logic                 cfg_pad_in,
    input  logic [CLK_SEL_W-1:0] cfg_clk_sel,
    input  logic                 cfg_clk_inv,
    input  logic [1:0]           cfg_ce_src,
    input  logic [CE_IDX_W-1:0]  cfg_ce_idx,
    input  logic [1:0]           cfg_set_src,
    input  logic [SR_IDX_W-1:0]  cfg_set_idx,
    input  logic [1:0]           cfg_rst_src,
    input  logic [SR_IDX_W-1:0]  cfg_rst_idx,
    output logic                 reg_out,
    output logic                 comb_out
);

    logic       store_d;
    logic       clk_lvl;
    logic       ce_line;
    logic [1:0] sr_line;     // [0] = set, [1] = reset
    logic [1:0] sr_src [2];
    logic [SR_IDX_W-1:0] sr_idx [2];
    logic [1:0] sr_pt;

    // Gather set/reset selection inputs into arrays for the generate loop.
    always_comb begin
        sr_src[0] = cfg_set_src;
        sr_src[1] = cfg_rst_src;
        sr_idx[0] = cfg_set_idx;
        sr_idx[1] = cfg_rst_idx;
        sr_pt     = {pt_rst, pt_set};
    end

    mc_logic_path u_path (
        .sum_pt      (sum_pt),
        .xor_pt      (xor_pt),
        .pad_in      (pad_in),
        .cfg_xor_sel (cfg_xor_sel),
        .cfg_pad_in  (cfg_pad_in),
        .comb_val    (comb_out),
        .store_d     (store_d)
    );

    mc_clk_pick #(
        .NUM_GCLK (NUM_GCLK),
        .SEL_W    (CLK_SEL_W)
    ) u_clk (
        .gclk   (gclk),
        .pt_clk (pt_clk),
        .sel    (cfg_clk_sel),
        .inv    (cfg_clk_inv),
        .lvl    (clk_lvl)
    );

    mc_line_pick #(
        .NUM     (NUM_GCE),
        .IDX_W   (CE_IDX_W),
        .OFF_VAL (1'b1)
    ) u_ce (
        .src  (cfg_ce_src),
        .idx  (cfg_ce_idx),
        .glob (gce),
        .pt   (pt_ce),
        .line (ce_line)
    );

    for (genvar g = 0; g < 2; g++) begin : g_sr
        mc_line_pick #(
            .NUM     (NUM_GSR),
            .IDX_W   (SR_IDX_W),
            .OFF_VAL (1'b0)
        ) u_sr (
            .src  (sr_src[g]),
            .idx  (sr_idx[g]),
            .glob (gsr),
            .pt   (sr_pt[g]),
            .line (sr_line[g])
        );
    end

    mc_storage u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (cfg_mode),
        .lvl   (clk_lvl),
        .ce    (ce_line),
        .set_l (sr_line[0]),
        .rst_l (sr_line[1]),
        .d     (store_d),
        .q     (reg_out)
    );

endmodule

// File: rtl/pld_macrocell_chk.sv
// Module: assertion checker for pld_macrocell, attached by bind.
// Rebuilds the selected control levels from the ports on its own and
// relates them to the outputs over time.
module pld_macrocell_chk #(
    parameter int NUM_GCLK  = 4,
    parameter int NUM_GCE   = 2,
    parameter int NUM_GSR   = 2,
    parameter int CLK_SEL_W = 3,
    parameter int CE_IDX_W  = 1,
    parameter int SR_IDX_W  = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sum_pt,
    input logic                 xor_pt,
    input logic                 pad_in,
    input logic [NUM_GCLK-1:0]  gclk,
    input logic                 pt_clk,
    input logic [NUM_GCE-1:0]   gce,
    input logic                 pt_ce,
    input logic [NUM_GSR-1:0]   gsr,
    input logic                 pt_set,
    input logic                 pt_rst,
    input logic [1:0]           cfg_mode,
    input logic [1:0]           cfg_xor_sel,
    input logic                 cfg_pad_in,
    input logic [CLK_SEL_W-1:0] cfg_clk_sel,
    input logic                 cfg_clk_inv,
    input logic [1:0]           cfg_ce_src,
    input logic [CE_IDX_W-1:0]  cfg_ce_idx,
    input logic [1:0]           cfg_set_src,
    input logic [SR_IDX_W-1:0]  cfg_set_idx,
    input logic [1:0]           cfg_rst_src,
    input logic [SR_IDX_W-1:0]  cfg_rst_idx,
    input logic                 reg_out,
    input logic                 comb_out
);

    logic exp_comb, exp_d, lvl_c, ce_c, set_c, rst_c, prev_c, edge_c;

    // Rebuild the expected selections from the port values.
    always_comb begin
        exp_comb = sum_pt ^ ((cfg_xor_sel == 2'd1) ? 1'b1 :
                             (cfg_xor_sel == 2'd2) ? xor_pt : 1'b0);
        exp_d = cfg_pad_in ? pad_in : exp_comb;
        lvl_c = (int'(cfg_clk_sel) < NUM_GCLK) ? gclk[cfg_clk_sel] : pt_clk;
        lvl_c = lvl_c ^ cfg_clk_inv;
        ce_c  = (cfg_ce_src == 2'd1) ?
                ((int'(cfg_ce_idx) < NUM_GCE) ? gce[cfg_ce_idx] : 1'b0) :
                (cfg_ce_src == 2'd2) ? pt_ce : 1'b1;
        set_c = (cfg_set_src == 2'd1) ?
                ((int'(cfg_set_idx) < NUM_GSR) ? gsr[cfg_set_idx] : 1'b0) :
                (cfg_set_src == 2'd2) ? pt_set : 1'b0;
        rst_c = (cfg_rst_src == 2'd1) ?
                ((int'(cfg_rst_idx) < NUM_GSR) ? gsr[cfg_rst_idx] : 1'b0) :
                (cfg_rst_src == 2'd2) ? pt_rst : 1'b0;
        edge_c = lvl_c & ~prev_c;
    end

    // Keep an independent history of the selected clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_c <= 1'b1;
        else        prev_c <= lvl_c;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> reg_out == 1'b0); // R1
    AST_COMB_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        comb_out == exp_comb); // R2
    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_c |=> reg_out == 1'b0); // R10
    AST_SET_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        (set_c && !rst_c) |=> reg_out == 1'b1); // R9
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_c && !set_c && !rst_c) |=> $stable(reg_out)); // R8
    AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode != 2'd1 && !edge_c && !set_c && !rst_c) |=> $stable(reg_out)); // R11
    AST_TOGGLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd2 && !exp_d && !set_c && !rst_c) |=> $stable(reg_out)); // R6

endmodule

bind pld_macrocell pld_macrocell_chk #(
    .NUM_GCLK  (NUM_GCLK),
    .NUM_GCE   (NUM_GCE),
    .NUM_GSR   (NUM_GSR),
    .CLK_SEL_W (CLK_SEL_W),
    .CE_IDX_W  (CE_IDX_W),
    .SR_IDX_W  (SR_IDX_W)
) u_chk (.*);

// File: tb/pld_macrocell_bench.sv
// Bench: seeded random sweep of all configurations plus directed corners,
// compared each cycle against a behavioural model built from the brief.
module pld_macrocell_bench;

    localparam int NG  = 4;
    localparam int NCE = 2;
    localparam int NSR = 2;
    localparam int CSW = $clog2(NG + 1);
    localparam int CEW = (NCE > 1) ? $clog2(NCE) : 1;
    localparam int SRW = (NSR > 1) ? $clog2(NSR) : 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sum_pt = 0, xor_pt = 0, pad_in = 0, pt_clk = 0, pt_ce = 0;
    logic pt_set = 0, pt_rst = 0;
    logic [NG-1:0]  gclk = '0;
    logic [NCE-1:0] gce = '0;
    logic [NSR-1:0] gsr = '0;
    logic [1:0] cfg_mode = 0, cfg_xor_sel = 0, cfg_ce_src = 0;
    logic [1:0] cfg_set_src = 0, cfg_rst_src = 0;
    logic cfg_pad_in = 0, cfg_clk_inv = 0;
    logic [CSW-1:0] cfg_clk_sel = '0;
    logic [CEW-1:0] cfg_ce_idx = '0;
    logic [SRW-1:0] cfg_set_idx = '0, cfg_rst_idx = '0;
    logic reg_out, comb_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic q_m = 0;
    logic prev_m = 1;
    string tag_m = "R1";

    always #5 clk = ~clk;

    pld_macrocell #(.NUM_GCLK(NG), .NUM_GCE(NCE), .NUM_GSR(NSR)) u_pld_macrocell (
        .clk(clk), .rst_n(rst_n), .sum_pt(sum_pt), .xor_pt(xor_pt),
        .pad_in(pad_in), .gclk(gclk), .pt_clk(pt_clk), .gce(gce),
        .pt_ce(pt_ce), .gsr(gsr), .pt_set(pt_set), .pt_rst(pt_rst),
        .cfg_mode(cfg_mode), .cfg_xor_sel(cfg_xor_sel), .cfg_pad_in(cfg_pad_in),
        .cfg_clk_sel(cfg_clk_sel), .cfg_clk_inv(cfg_clk_inv),
        .cfg_ce_src(cfg_ce_src), .cfg_ce_idx(cfg_ce_idx),
        .cfg_set_src(cfg_set_src), .cfg_set_idx(cfg_set_idx),
        .cfg_rst_src(cfg_rst_src), .cfg_rst_idx(cfg_rst_idx),
        .reg_out(reg_out), .comb_out(comb_out));

    // R2 expected combinatorial value
    function automatic logic f_comb();
        case (cfg_xor_sel)
            2'd1:    return ~sum_pt;
            2'd2:    return sum_pt ^ xor_pt;
            default: return sum_pt;
        endcase
    endfunction

    // R3 expected storage data
    function automatic logic f_data();
        return cfg_pad_in ? pad_in : f_comb();
    endfunction

    // R7 expected clock level
    function automatic logic f_clk();
        logic r;
        r = (int'(cfg_clk_sel) < NG) ? gclk[cfg_clk_sel] : pt_clk;
        return r ^ cfg_clk_inv;
    endfunction

    // R8 / R9 expected control line from a source code
    function automatic logic f_line(input logic [1:0] src, input int idx,
                                    input logic [NSR-1:0] bank, input int n,
                                    input logic pt, input logic off);
        if (src == 2'd1) return (idx < n) ? bank[idx] : 1'b0;
        if (src == 2'd2) return pt;
        return off;
    endfunction

    // Behavioural model, updated at each system-clock edge.
    always @(posedge clk) begin
        logic lvl, ce, s, r, d, ed;
        if (!rst_n) begin
            q_m = 0; prev_m = 1; tag_m = "R1";
        end else begin
            lvl = f_clk();
            ce  = f_line(cfg_ce_src, int'(cfg_ce_idx), NSR'(gce), NCE, pt_ce, 1'b1);
            s   = f_line(cfg_set_src, int'(cfg_set_idx), gsr, NSR, pt_set, 1'b0);
            r   = f_line(cfg_rst_src, int'(cfg_rst_idx), gsr, NSR, pt_rst, 1'b0);
            d   = f_data();
            ed  = lvl & ~prev_m;
            if (r) begin
                q_m = 0; tag_m = s ? "R10" : "R9";
            end else if (s) begin
                q_m = 1; tag_m = "R9";
            end else if (!ce) begin
                tag_m = "R8 R11";
            end else begin
                case (cfg_mode)
                    2'd1: begin if (lvl) q_m = d; tag_m = "R5 R7"; end
                    2'd2: begin if (ed && d) q_m = ~q_m; tag_m = ed ? "R6 R7" : "R6 R11"; end
                    default: begin if (ed) q_m = d; tag_m = ed ? "R4 R7" : "R4 R11"; end
                endcase
                if (cfg_pad_in) tag_m = {tag_m, " R3"};
            end
            prev_m = lvl;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rand_data();
        sum_pt = 1'($urandom); xor_pt = 1'($urandom); pad_in = 1'($urandom);
        gclk = NG'($urandom); pt_clk = 1'($urandom);
        gce = NCE'($urandom | $urandom); pt_ce = 1'($urandom | $urandom);
        for (int i = 0; i < NSR; i++) gsr[i] = ($urandom % 8) == 0;
        pt_set = ($urandom % 8) == 0; pt_rst = ($urandom % 8) == 0;
    endtask

    task automatic rand_cfg();
        cfg_mode = 2'($urandom); cfg_xor_sel = 2'($urandom);
        cfg_pad_in = 1'($urandom); cfg_clk_sel = CSW'($urandom);
        cfg_clk_inv = 1'($urandom); cfg_ce_src = 2'($urandom);
        cfg_ce_idx = CEW'($urandom); cfg_set_src = 2'($urandom);
        cfg_set_idx = SRW'($urandom); cfg_rst_src = 2'($urandom);
        cfg_rst_idx = SRW'($urandom);
    endtask

    // One cycle: check stored output, optionally new inputs, check comb path.
    task automatic tick(input bit rnd);
        @(negedge clk);
        check(tag_m, reg_out, q_m);
        if (rnd) rand_data();
        #1 check("R2", comb_out, f_comb());
    endtask

    task automatic quiet_cfg(input logic [1:0] mode);
        cfg_mode = mode; cfg_xor_sel = 0; cfg_pad_in = 0; cfg_clk_sel = '0;
        cfg_clk_inv = 0; cfg_ce_src = 0; cfg_set_src = 0; cfg_rst_src = 0;
        cfg_ce_idx = '0; cfg_set_idx = '0; cfg_rst_idx = '0;
        pt_set = 0; pt_rst = 0; gsr = '0; gclk = '0; pt_clk = 0;
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 0;
        quiet_cfg(2'd0);
        gclk[0] = 1'b1;                  // R1: clock high across reset release
        sum_pt = 1;
        repeat (3) @(negedge clk);
        check("R1", reg_out, 1'b0);
        rst_n = 1;
        tick(0);                         // high clock at release: no edge (R1)
        check("R1", reg_out, 1'b0);
        // R10: set and reset from product terms together
        pt_set = 1; pt_rst = 1; cfg_set_src = 2'd2; cfg_rst_src = 2'd2;
        tick(0); tick(0);
        check("R10", reg_out, 1'b0);
        pt_rst = 0; tick(0); tick(0);
        check("R9", reg_out, 1'b1);
        // R5: latch follows while high, holds when low
        quiet_cfg(2'd1); sum_pt = 0; gclk[0] = 1; tick(0); tick(0);
        check("R5", reg_out, 1'b0);
        gclk[0] = 0; sum_pt = 1; tick(0); tick(0);
        check("R5", reg_out, 1'b0);
        // R3: pad path into a D register via the product-term clock (R7)
        quiet_cfg(2'd0); cfg_pad_in = 1; cfg_clk_sel = CSW'(NG); pad_in = 1; sum_pt = 0;
        tick(0); pt_clk = 1; tick(0); tick(0);
        check("R3", reg_out, 1'b1);
        // R6: toggle with data 0 holds, data 1 inverts
        quiet_cfg(2'd2); sum_pt = 0; tick(0); gclk[0] = 1; tick(0); tick(0);
        check("R6", reg_out, 1'b1);
        gclk[0] = 0; sum_pt = 1; tick(0); gclk[0] = 1; tick(0); tick(0);
        check("R6", reg_out, 1'b0);
        // R8: disabled by global enable, edges ignored
        quiet_cfg(2'd0); cfg_ce_src = 2'd1; gce = '0; sum_pt = 1; tick(0);
        gclk[0] = 1; tick(0); tick(0);
        check("R8", reg_out, 1'b0);
        // Random sweep over every mode and source
        for (int blk = 0; blk < 300; blk++) begin
            rand_cfg();
            for (int c = 0; c < 16; c++) tick(1);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule